// File: doc/BRIEF.md
# Inbound BAR Match Address Translator

This block sits behind the packet parser of a PCI Express endpoint. It takes the 64-bit address of each inbound memory request and compares it against a small bank of programmable base address registers (BARs). Each BAR is a power-of-two window. Its low offset bits are carried through untouched. The bits above the window size are swapped for a local base, which gives a 32-bit byte address for the on-chip memory-mapped master.

Every BAR slot stores a base word, a control word (size, 64-bit pairing, prefetchable flag) and a local base. An even slot marked as 64-bit takes the next slot as the upper half of its base. A hit delivers the winning slot index, its prefetchable flag and the translated address one clock after the request is accepted, behind a valid/ready handshake. A request that hits nothing raises a one-cycle miss flag, so that an unsupported-request completion can be produced elsewhere. With the root-port input high, matching is skipped and every request goes out on slot 0 carrying its low 32 address bits.

Top module: `bxl_top`

## Requirements
- R1: After reset, out_valid and miss are low, req_ready is high, and every configuration field reads back 0. Every BAR is disabled, so any request misses.
- R2: An even slot whose control bit 8 is set pairs with the next slot, which holds address bits 63:32. A request hits when all of its bits above the size boundary equal the 64-bit base.
- R3: On a hit, out_addr is made of the low size bits of the request address, with the local base bits above the size boundary placed over them.
- R4: A BAR without pairing matches only requests whose address bits 63:32 are all zero.
- R5: A slot whose size field (control bits 4:0, log2 of the window) is 0 never matches. Control bit 8 written to an odd slot is stored as 0, so that slot stays a 32-bit BAR.
- R6: When several BARs match, out_bar reports the lowest-numbered one.
- R7: An accepted request that hits nothing raises miss for exactly one cycle and does not raise out_valid.
- R8: The result of an accepted request appears on the outputs at the first clock edge after acceptance.
- R9: While out_valid is high and out_ready is low, req_ready is low, and out_bar and out_addr hold their values.
- R10: Base bits below the size boundary are stored as zero. This holds when the base is written and again when a new size is written. Read-back shows the cleared bits.
- R11: A nonzero size below 12 is stored as 12, and a size above MAX_LOG2 is stored as MAX_LOG2.
- R12: With root_mode high, every accepted request raises out_valid with out_bar 0, out_pref 0, and out_addr equal to request bits 31:0. It never raises miss.
- R13: out_pref reports control bit 9 of the winning slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_mode | input | 1 | Skip matching and forward every request to slot 0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Slot written |
| cfg_field | input | 2 | Field written: 0 base, 1 control, 2 local base |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_slot | input | 3 | Slot read |
| cfg_rd_field | input | 2 | Field read (same coding; 3 reads 0) |
| cfg_rdata | output | 32 | Read data, registered one cycle after the select |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 64 | Request byte address |
| out_valid | output | 1 | Hit result valid |
| out_ready | input | 1 | Downstream master takes the result |
| out_bar | output | 3 | Winning slot index |
| out_pref | output | 1 | Prefetchable flag of the winning slot |
| out_addr | output | 32 | Translated local byte address |
| miss | output | 1 | One-cycle pulse for an unmatched request |

## Verification
The bench builds the block with its default parameters: six slots, a 4 KiB minimum window and a MAX_LOG2 of 28. Six slots make room for a 64-bit pair on slots 0 and 1, for overlapping 32-bit windows on slots 2 and 5 to test priority, and for an odd slot 3 where the pairing bit must be refused. A MAX_LOG2 below 31 makes clamping from above visible through read-back. The bench also covers back-pressure with a second request pending, and root-port forwarding of an address whose upper bits are nonzero.

// File: rtl/bxl_pkg.sv
package bxl_pkg;
  localparam int REG_W = 32;
  localparam int SZ_W  = 5;

  localparam logic [1:0] FLD_BASE  = 2'd0;
  localparam logic [1:0] FLD_CTRL  = 2'd1;
  localparam logic [1:0] FLD_LBASE = 2'd2;

  localparam int CTRL_PAIR_BIT = 8;
  localparam int CTRL_PREF_BIT = 9;

  typedef struct packed {
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] lbase;
    logic [SZ_W-1:0]  size;
    logic             is64;
    logic             pref;
  } bar_cfg_t;

  function automatic logic [REG_W-1:0] low_mask(input logic [SZ_W-1:0] sz);
    logic [REG_W:0] one_sh;
    one_sh = {{REG_W{1'b0}}, 1'b1} << sz;
    if (sz == '0) return '0;
    return one_sh[REG_W-1:0] - {{(REG_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/bxl_cfg_regs.sv
module bxl_cfg_regs
  import bxl_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter int MIN_LOG2 = 12,
  parameter int MAX_LOG2 = 28,
  parameter int SLOT_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [1:0]        cfg_field,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [SLOT_W-1:0] cfg_rd_slot,
  input  logic [1:0]        cfg_rd_field,
  output logic [REG_W-1:0]  cfg_rdata,
  output bar_cfg_t          bars [NUM_BARS]
);
  logic [SZ_W-1:0] wr_sz;

  always_comb begin
    wr_sz = cfg_wdata[SZ_W-1:0];
    if (wr_sz != '0) begin
      if (int'(wr_sz) < MIN_LOG2)      wr_sz = SZ_W'(MIN_LOG2);
      else if (int'(wr_sz) > MAX_LOG2) wr_sz = SZ_W'(MAX_LOG2);
    end
  end

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
    localparam bit CAN_PAIR = (i % 2 == 0) && (i + 1 < NUM_BARS);
    logic sel;
    assign sel = cfg_we && (cfg_slot == SLOT_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        bars[i] <= '0;
      end else if (sel) begin
        case (cfg_field)
          FLD_BASE:  bars[i].base <= cfg_wdata & ~low_mask(bars[i].size);
          FLD_CTRL: begin
            bars[i].size <= wr_sz;
            bars[i].is64 <= CAN_PAIR ? cfg_wdata[CTRL_PAIR_BIT] : 1'b0;
            bars[i].pref <= cfg_wdata[CTRL_PREF_BIT];
            bars[i].base <= bars[i].base & ~low_mask(wr_sz);
          end
          FLD_LBASE: bars[i].lbase <= cfg_wdata;
          default: ;
        endcase
      end
    end

    // R10: stored base never keeps bits below its window boundary
    a_r10_base_aligned: assert property (@(posedge clk) disable iff (rst)
      (bars[i].base & low_mask(bars[i].size)) == '0);
    // R11: stored size is disabled or within the legal range
    a_r11_size_range: assert property (@(posedge clk) disable iff (rst)
      (bars[i].size == '0) ||
      ((int'(bars[i].size) >= MIN_LOG2) && (int'(bars[i].size) <= MAX_LOG2)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      cfg_rdata <= '0;
      for (int k = 0; k < NUM_BARS; k++) begin
        if (cfg_rd_slot == SLOT_W'(k)) begin
          case (cfg_rd_field)
            FLD_BASE:  cfg_rdata <= bars[k].base;
            FLD_CTRL: begin
              cfg_rdata <= '0;
              cfg_rdata[SZ_W-1:0]     <= bars[k].size;
              cfg_rdata[CTRL_PAIR_BIT] <= bars[k].is64;
              cfg_rdata[CTRL_PREF_BIT] <= bars[k].pref;
            end
            FLD_LBASE: cfg_rdata <= bars[k].lbase;
            default:   cfg_rdata <= '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/bxl_match.sv
module bxl_match
  import bxl_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter int SLOT_W   = 3
) (
  input  bar_cfg_t            bars [NUM_BARS],
  input  logic [2*REG_W-1:0]  addr,
  input  logic                root_mode,
  output logic                hit,
  output logic [SLOT_W-1:0]   idx,
  output logic                pref,
  output logic [REG_W-1:0]    laddr
);
  logic [REG_W-1:0] addr_lo, addr_hi;
  logic [NUM_BARS-1:0] hit_vec;
  logic [REG_W-1:0] laddr_arr [NUM_BARS];

  assign addr_lo = addr[REG_W-1:0];
  assign addr_hi = addr[2*REG_W-1:REG_W];

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_cmp
    logic [REG_W-1:0] m;
    logic hi_ok, shadowed, en;
    assign m = low_mask(bars[i].size);

    if ((i % 2 == 0) && (i + 1 < NUM_BARS)) begin : g_pair
      assign hi_ok = bars[i].is64 ? (addr_hi == bars[i+1].base) : (addr_hi == '0);
    end else begin : g_single
      assign hi_ok = (addr_hi == '0);
    end

    if (i % 2 == 1) begin : g_upper
      assign shadowed = bars[i-1].is64;
    end else begin : g_lower
      assign shadowed = 1'b0;
    end

    assign en           = (bars[i].size != '0) && !shadowed;
    assign hit_vec[i]   = en && hi_ok && ((addr_lo & ~m) == bars[i].base);
    assign laddr_arr[i] = (bars[i].lbase & ~m) | (addr_lo & m);
  end

  always_comb begin
    hit   = 1'b0;
    idx   = '0;
    pref  = 1'b0;
    laddr = '0;
    if (root_mode) begin
      hit   = 1'b1;
      laddr = addr_lo;
    end else begin
      for (int k = NUM_BARS - 1; k >= 0; k--) begin
        if (hit_vec[k]) begin
          hit   = 1'b1;
          idx   = SLOT_W'(k);
          pref  = bars[k].pref;
          laddr = laddr_arr[k];
        end
      end
    end
  end
endmodule

// File: rtl/bxl_out_stage.sv
module bxl_out_stage
  import bxl_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter int SLOT_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              m_hit,
  input  logic [SLOT_W-1:0] m_idx,
  input  logic              m_pref,
  input  logic [REG_W-1:0]  m_laddr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SLOT_W-1:0] out_bar,
  output logic              out_pref,
  output logic [REG_W-1:0]  out_addr,
  output logic              miss
);
  logic take;
  assign req_ready = !out_valid || out_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      miss      <= 1'b0;
      out_bar   <= '0;
      out_pref  <= 1'b0;
      out_addr  <= '0;
    end else begin
      miss <= 1'b0;
      if (take) begin
        out_valid <= m_hit;
        miss      <= !m_hit;
        if (m_hit) begin
          out_bar  <= m_idx;
          out_pref <= m_pref;
          out_addr <= m_laddr;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9: a stalled result stays put
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bar) && $stable(out_addr)));
  // R7: a miss pulse never coincides with a valid result
  a_r7_miss_excl: assert property (@(posedge clk) disable iff (rst)
    miss |-> !out_valid);
  // R8: a new result or miss follows an accepted request
  a_r8_after_accept: assert property (@(posedge clk) disable iff (rst)
    ($rose(out_valid) || miss) |-> $past(req_valid && req_ready));
  // R6: reported index names an existing slot
  a_r6_idx_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_bar) < NUM_BARS));
endmodule

// File: rtl/bxl_top.sv
module bxl_top
  import bxl_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter int MIN_LOG2 = 12,
  parameter int MAX_LOG2 = 28,
  localparam int SLOT_W  = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              root_mode,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [1:0]        cfg_field,
  input  logic [31:0]       cfg_wdata,
  input  logic [SLOT_W-1:0] cfg_rd_slot,
  input  logic [1:0]        cfg_rd_field,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SLOT_W-1:0] out_bar,
  output logic              out_pref,
  output logic [31:0]       out_addr,
  output logic              miss
);
  bar_cfg_t          bars [NUM_BARS];
  logic              m_hit, m_pref;
  logic [SLOT_W-1:0] m_idx;
  logic [REG_W-1:0]  m_laddr;

  bxl_cfg_regs #(.NUM_BARS(NUM_BARS), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2),
                 .SLOT_W(SLOT_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .cfg_rd_slot(cfg_rd_slot),
    .cfg_rd_field(cfg_rd_field), .cfg_rdata(cfg_rdata), .bars(bars)
  );

  bxl_match #(.NUM_BARS(NUM_BARS), .SLOT_W(SLOT_W)) u_match (
    .bars(bars), .addr(req_addr), .root_mode(root_mode),
    .hit(m_hit), .idx(m_idx), .pref(m_pref), .laddr(m_laddr)
  );

  bxl_out_stage #(.NUM_BARS(NUM_BARS), .SLOT_W(SLOT_W)) u_out (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .m_hit(m_hit), .m_idx(m_idx), .m_pref(m_pref), .m_laddr(m_laddr),
    .out_valid(out_valid), .out_ready(out_ready), .out_bar(out_bar),
    .out_pref(out_pref), .out_addr(out_addr), .miss(miss)
  );

  // R12: root-port forwarding never reports a miss
  a_r12_root_no_miss: assert property (@(posedge clk) disable iff (rst)
    miss |-> !$past(root_mode));
endmodule

// File: tb/bxl_top_tb_top.sv
module bxl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        root_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_slot = '0;
  logic [1:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  cfg_rd_slot = '0;
  logic [1:0]  cfg_rd_field = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_bar;
  logic        out_pref;
  logic [31:0] out_addr;
  logic        miss;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bxl_top dut_i (
    .clk(clk), .rst(rst), .root_mode(root_mode), .cfg_we(cfg_we),
    .cfg_slot(cfg_slot), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .cfg_rd_slot(cfg_rd_slot), .cfg_rd_field(cfg_rd_field), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_bar(out_bar),
    .out_pref(out_pref), .out_addr(out_addr), .miss(miss)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] slot, input logic [1:0] fld, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = slot; cfg_field = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] slot, input logic [1:0] fld,
                        input logic [31:0] exp);
    @(negedge clk);
    cfg_rd_slot = slot; cfg_rd_field = fld;
    @(negedge clk);
    chk(tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic send_chk(input string tag, input logic [63:0] a, input logic exp_hit,
                          input logic [2:0] exp_bar, input logic [31:0] exp_addr,
                          input logic exp_pref);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 64'(out_valid), 64'(exp_hit));
    chk({tag, " miss"}, 64'(miss), 64'(!exp_hit));
    if (exp_hit) begin
      chk({tag, " bar"}, 64'(out_bar), 64'(exp_bar));
      chk({tag, " addr"}, 64'(out_addr), 64'(exp_addr));
      chk({tag, " pref"}, 64'(out_pref), 64'(exp_pref));
    end else begin
      @(negedge clk);
      chk({tag, " R7 miss one cycle"}, 64'(miss), 64'd0);
    end
  endtask

  task automatic t_reset;
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 miss", 64'(miss), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    rd_chk("R1 ctrl slot0", 3'd0, 2'd1, 32'd0);
    rd_chk("R1 base slot2", 3'd2, 2'd0, 32'd0);
    send_chk("R1 all disabled", 64'h0, 1'b0, 3'd0, 32'd0, 1'b0);
  endtask

  task automatic t_pair64;
    wr(3'd0, 2'd1, 32'h0000_010C);
    wr(3'd0, 2'd0, 32'h5678_9000);
    wr(3'd1, 2'd0, 32'h0000_1234);
    wr(3'd0, 2'd2, 32'h4000_0000);
    send_chk("R2 R3 R8 pair hit", 64'h0000_1234_5678_9870, 1'b1, 3'd0, 32'h4000_0870, 1'b0);
    send_chk("R2 pair low mismatch", 64'h0000_1234_5678_8870, 1'b0, 3'd0, 32'd0, 1'b0);
    send_chk("R2 pair high mismatch", 64'h0000_1235_5678_9870, 1'b0, 3'd0, 32'd0, 1'b0);
  endtask

  task automatic t_bar32;
    wr(3'd2, 2'd1, 32'h0000_0210);
    wr(3'd2, 2'd0, 32'h8000_0000);
    wr(3'd2, 2'd2, 32'h1000_0000);
    send_chk("R3 R13 bar2 hit", 64'h0000_0000_8000_1234, 1'b1, 3'd2, 32'h1000_1234, 1'b1);
    send_chk("R4 upper nonzero", 64'h0000_0001_8000_1234, 1'b0, 3'd0, 32'd0, 1'b0);
  endtask

  task automatic t_priority;
    wr(3'd5, 2'd1, 32'h0000_0014);
    wr(3'd5, 2'd0, 32'h800A_BCDE);
    wr(3'd5, 2'd2, 32'h2000_0000);
    rd_chk("R10 base masked on write", 3'd5, 2'd0, 32'h8000_0000);
    send_chk("R6 overlap lowest wins", 64'h8000_1234, 1'b1, 3'd2, 32'h1000_1234, 1'b1);
    send_chk("R6 only bar5", 64'h8005_1234, 1'b1, 3'd5, 32'h2005_1234, 1'b0);
  endtask

  task automatic t_disable_odd;
    wr(3'd3, 2'd0, 32'h9000_0000);
    send_chk("R5 size0 disabled", 64'h9000_0000, 1'b0, 3'd0, 32'd0, 1'b0);
    wr(3'd4, 2'd0, 32'h0000_0001);
    wr(3'd3, 2'd1, 32'h0000_010C);
    rd_chk("R5 odd pair bit dropped", 3'd3, 2'd1, 32'h0000_000C);
    send_chk("R5 odd slot not paired", 64'h0000_0001_9000_0000, 1'b0, 3'd0, 32'd0, 1'b0);
    send_chk("R5 odd slot as 32-bit", 64'h9000_0abc, 1'b1, 3'd3, 32'h0000_0abc, 1'b0);
    wr(3'd3, 2'd0, 32'h9000_1234);
    rd_chk("R10 base 12-bit aligned", 3'd3, 2'd0, 32'h9000_1000);
    wr(3'd3, 2'd1, 32'h0000_0010);
    rd_chk("R10 remask on size change", 3'd3, 2'd0, 32'h9000_0000);
  endtask

  task automatic t_clamp;
    wr(3'd4, 2'd1, 32'h0000_0005);
    rd_chk("R11 clamp low", 3'd4, 2'd1, 32'h0000_000C);
    wr(3'd4, 2'd1, 32'h0000_001F);
    rd_chk("R11 clamp high", 3'd4, 2'd1, 32'h0000_001C);
    wr(3'd4, 2'd1, 32'h0000_0000);
    rd_chk("R5 size back to 0", 3'd4, 2'd1, 32'h0000_0000);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0; req_valid = 1'b1; req_addr = 64'h8000_1111;
    @(negedge clk);
    chk("R9 first valid", 64'(out_valid), 64'd1);
    chk("R9 first addr", 64'(out_addr), 64'h1000_1111);
    chk("R9 ready low", 64'(req_ready), 64'd0);
    req_addr = 64'h8005_2222;
    @(negedge clk);
    chk("R9 held addr", 64'(out_addr), 64'h1000_1111);
    chk("R9 held bar", 64'(out_bar), 64'd2);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 next bar", 64'(out_bar), 64'd5);
    chk("R9 next addr", 64'(out_addr), 64'h2005_2222);
    @(negedge clk);
    chk("R9 drained", 64'(out_valid), 64'd0);
  endtask

  task automatic t_root;
    root_mode = 1'b1;
    send_chk("R12 root forward", 64'h0000_00FF_DEAD_BEE8, 1'b1, 3'd0, 32'hDEAD_BEE8, 1'b0);
    send_chk("R12 root any addr", 64'h0000_0000_0000_0010, 1'b1, 3'd0, 32'h0000_0010, 1'b0);
    root_mode = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pair64();
    t_bar32();
    t_priority();
    t_disable_odd();
    t_clamp();
    t_backpressure();
    t_root();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule